// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen architectural general registers of a processor that runs in several operating modes. Some registers exist in more than one physical copy, and the mode currently held in the block decides which copy an architectural index reaches. The core sees two combinational read ports and one write port, all resolved through the current mode. A separate debug port reads or writes any register as it appears from a mode named on that port. This lets a debugger inspect the stored copies of modes that are not running.

A 5-bit mode number is loaded through a mode-change input and decoded into a bank index. The fast-interrupt bank holds private copies of R8 to R14. The interrupt, supervisor, abort and undefined banks hold private copies of R13 and R14 only. The user and system banks share everything. Every unlisted mode number selects a dummy bank. In that bank R8 to R14 start out as zero on entry, act as scratch while the mode stays in the bank, and are lost on exit.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register reads zero, the current mode is RESET_MODE (default 19), and the bank output shows the bank of that mode.
- R2: The bank output encodes 0 user, 1 fast-interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6 dummy and 7 system. Modes 0-3 and 16-19 give banks 0-3, mode 23 gives 4, mode 27 gives 5, mode 31 gives 7, and all other modes give 6.
- R3: With mode_we high at a clock edge, mode_in becomes the current mode, and the next core access uses the new mapping. A core write in the same cycle as mode_we uses the old mode.
- R4: R0-R7 and R15 have one physical copy that every mode and the debug port share.
- R5: In the fast-interrupt bank, R8-R14 reach a private copy.
- R6: In banks 2-5, R13 and R14 reach a private copy per bank, and R8-R12 reach the user copy.
- R7: The system bank reaches the user copy for every index, including R13 and R14.
- R8: Entering the dummy bank from another bank makes R8-R14 read zero. Writes made while in the bank stay readable, including across a change to another dummy mode number. After leaving and re-entering, R8-R14 read zero again.
- R9: A debug access to a mode in the current bank uses the live registers. A debug access to a mode in another bank uses that mode's stored copy. A debug access to a dummy mode while not in the dummy bank reads zero and does not write.
- R10: Reads are combinational. A write becomes visible on the read ports after the clock edge that takes it, and not before.
- R11: When the core port and the debug port write the same physical register in one cycle, the core data is kept.
- R12: A mode change between two modes of the same bank leaves every register value as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load mode_in as the current mode |
| mode_in | input | 5 | New mode number |
| cur_mode_o | output | 5 | Current mode number |
| cur_bank_o | output | 3 | Bank index of the current mode |
| ra_addr | input | 4 | Read port A index |
| ra_data | output | DW | Read port A data |
| rb_addr | input | 4 | Read port B index |
| rb_data | output | DW | Read port B data |
| we | input | 1 | Core write enable |
| waddr | input | 4 | Core write index |
| wdata | input | DW | Core write data |
| dbg_mode | input | 5 | Mode through which the debug port views registers |
| dbg_addr | input | 4 | Debug register index |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | DW | Debug write data |
| dbg_rdata | output | DW | Debug read data |

## Verification
The bench steps through all 32 mode numbers. In each mode it writes every index through the core port, then reads all sixteen registers through both core ports and through the debug port from every mode. A mapping that banks R8-R12 outside the fast-interrupt mode, or shares R13 between the system and supervisor banks wrongly, therefore shows up as data leaking between modes. The bench also targets the dummy bank, where a design that skips the clear on entry returns stale scratch data, and one that clears on moves between dummy modes loses live values. It also drives core writes in the same cycle as a mode change and core and debug writes that collide in one cycle, where a wrong priority lands data in the wrong copy.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32,
  parameter logic [4:0] RESET_MODE = 5'd19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [4:0]    mode_in,
  output logic [4:0]    cur_mode_o,
  output logic [2:0]    cur_bank_o,
  input  logic [3:0]    ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [3:0]    waddr,
  input  logic [DW-1:0] wdata,
  input  logic [4:0]    dbg_mode,
  input  logic [3:0]    dbg_addr,
  input  logic          dbg_we,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata
);
  localparam logic [2:0] B_FIQ = 3'd1, B_ABT = 3'd4, B_UND = 3'd5, B_DUM = 3'd6;
  localparam int FIQ_BASE = 16;
  localparam int PRV_BASE = FIQ_BASE + 7;
  localparam int DUM_BASE = PRV_BASE + 8;
  localparam int NPHYS    = DUM_BASE + 7;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    if (m[3:2] == 2'b00) return {1'b0, m[1:0]};
    case (m)
      5'd23:   return B_ABT;
      5'd27:   return B_UND;
      5'd31:   return 3'd7;
      default: return B_DUM;
    endcase
  endfunction

  function automatic logic [6:0] slot(input logic [2:0] b, input logic [3:0] idx, input logic live);
    int s;
    logic ok;
    s  = int'(idx);
    ok = 1'b1;
    if (idx >= 4'd8 && idx != 4'd15) begin
      if (b == B_FIQ) s = FIQ_BASE + int'(idx) - 8;
      else if (b >= 3'd2 && b <= B_UND && idx >= 4'd13)
        s = PRV_BASE + (int'(b) - 2) * 2 + int'(idx) - 13;
      else if (b == B_DUM) begin
        s  = DUM_BASE + int'(idx) - 8;
        ok = live;
      end
    end
    return {ok, 6'(s)};
  endfunction

  logic [DW-1:0] rf [NPHYS];
  logic [4:0] cur_mode;
  logic [2:0] cur_bank, dbg_bank;
  logic [6:0] sa, sb, sw, sd;

  assign cur_bank   = bank_of(cur_mode);
  assign dbg_bank   = bank_of(dbg_mode);
  assign cur_mode_o = cur_mode;
  assign cur_bank_o = cur_bank;

  assign sa = slot(cur_bank, ra_addr, 1'b1);
  assign sb = slot(cur_bank, rb_addr, 1'b1);
  assign sw = slot(cur_bank, waddr, 1'b1);
  assign sd = slot(dbg_bank, dbg_addr, dbg_bank == cur_bank);

  assign ra_data   = sa[6] ? rf[sa[5:0]] : '0;
  assign rb_data   = sb[6] ? rf[sb[5:0]] : '0;
  assign dbg_rdata = sd[6] ? rf[sd[5:0]] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode <= RESET_MODE;
      for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
    end else begin
      if (mode_we) begin
        cur_mode <= mode_in;
        if (bank_of(mode_in) == B_DUM && cur_bank != B_DUM)
          for (int i = DUM_BASE; i < NPHYS; i++) rf[i] <= '0;
      end
      if (dbg_we && sd[6]) rf[sd[5:0]] <= dbg_wdata;
      if (we && sw[6]) rf[sw[5:0]] <= wdata;
    end
  end
endmodule

module banked_regfile_chk #(parameter int DW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_we,
  input logic [4:0]    mode_in,
  input logic [4:0]    cur_mode_o,
  input logic [2:0]    cur_bank_o,
  input logic [3:0]    ra_addr,
  input logic [DW-1:0] ra_data,
  input logic          we,
  input logic [3:0]    waddr,
  input logic [DW-1:0] wdata,
  input logic [3:0]    dbg_addr,
  input logic          dbg_we
);
  // R3
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> cur_mode_o == $past(mode_in));

  // R10
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && ra_addr == $past(waddr) && cur_bank_o == $past(cur_bank_o))
      |-> ra_data == $past(wdata));

  // R4
  pc_unbanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == 4'd15 && $past(ra_addr) == 4'd15 &&
     !($past(we) && $past(waddr) == 4'd15) &&
     !($past(dbg_we) && $past(dbg_addr) == 4'd15)) |-> $stable(ra_data));

  // R8
  dummy_entry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_we) && cur_bank_o == 3'd6 && $past(cur_bank_o) != 3'd6 &&
     ra_addr >= 4'd8 && ra_addr != 4'd15) |-> ra_data == '0);

  // R12
  same_bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_we) && cur_bank_o == $past(cur_bank_o) && ra_addr == $past(ra_addr) &&
     !$past(we) && !$past(dbg_we)) |-> $stable(ra_data));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
  .cur_mode_o(cur_mode_o), .cur_bank_o(cur_bank_o), .ra_addr(ra_addr),
  .ra_data(ra_data), .we(we), .waddr(waddr), .wdata(wdata),
  .dbg_addr(dbg_addr), .dbg_we(dbg_we)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 0, we = 0, dbg_we = 0;
  logic [4:0] mode_in = 0, dbg_mode = 0, cur_mode_o;
  logic [2:0] cur_bank_o;
  logic [3:0] ra_addr = 0, rb_addr = 0, waddr = 0, dbg_addr = 0;
  logic [31:0] wdata = 0, dbg_wdata = 0, ra_data, rb_data, dbg_rdata;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  banked_regfile uut (.*);

  logic [31:0] usr [16];
  logic [31:0] fq [7];
  logic [31:0] pv [8];
  logic [31:0] dm [7];
  logic [4:0] mmode;

  function automatic logic [2:0] mb(input logic [4:0] m);
    if (m < 5'd4 || (m >= 5'd16 && m < 5'd20)) return 3'(m % 4);
    if (m == 5'd23) return 3'd4;
    if (m == 5'd27) return 3'd5;
    if (m == 5'd31) return 3'd7;
    return 3'd6;
  endfunction

  function automatic logic [31:0] mrd(input logic [2:0] b, input logic [3:0] r, input logic live);
    if (r < 8 || r == 15) return usr[r];
    if (b == 1) return fq[r-8];
    if (b >= 2 && b <= 5 && r >= 13) return pv[(b-2)*2 + (r-13)];
    if (b == 6) return live ? dm[r-8] : 32'd0;
    return usr[r];
  endfunction

  task automatic mwr(input logic [2:0] b, input logic [3:0] r, input logic live, input logic [31:0] d);
    if (r < 8 || r == 15) usr[r] = d;
    else if (b == 1) fq[r-8] = d;
    else if (b >= 2 && b <= 5 && r >= 13) pv[(b-2)*2 + (r-13)] = d;
    else if (b == 6) begin if (live) dm[r-8] = d; end
    else usr[r] = d;
  endtask

  function automatic string tagof(input logic [2:0] b, input logic [3:0] r);
    if (r < 8 || r == 15) return "R4";
    if (b == 1) return "R5";
    if (b >= 2 && b <= 5) return "R6";
    if (b == 6) return "R8";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) begin
      if (dbg_we) mwr(mb(dbg_mode), dbg_addr, mb(dbg_mode) == mb(mmode), dbg_wdata);
      if (we) mwr(mb(mmode), waddr, 1'b1, wdata);
      if (mode_we) begin
        if (mb(mode_in) == 6 && mb(mmode) != 6) for (int i = 0; i < 7; i++) dm[i] = 0;
        mmode = mode_in;
      end
    end
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [4:0] m);
    mode_in = m; mode_we = 1; tick(); mode_we = 0;
  endtask

  task automatic core_wr(input logic [3:0] r, input logic [31:0] d);
    waddr = r; wdata = d; we = 1; tick(); we = 0;
  endtask

  task automatic sweep_core();
    for (int r = 0; r < 16; r++) begin
      ra_addr = 4'(r); rb_addr = 4'(15 - r); #1;
      chk(tagof(mb(mmode), 4'(r)), ra_data, mrd(mb(mmode), 4'(r), 1'b1));
      chk(tagof(mb(mmode), 4'(15 - r)), rb_data, mrd(mb(mmode), 4'(15 - r), 1'b1));
    end
  endtask

  task automatic sweep_dbg();
    for (int m = 0; m < 32; m++)
      for (int r = 0; r < 16; r++) begin
        dbg_mode = 5'(m); dbg_addr = 4'(r); #1;
        chk("R9", dbg_rdata, mrd(mb(5'(m)), 4'(r), mb(5'(m)) == mb(mmode)));
      end
  endtask

  initial begin
    #(4 * 190000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) usr[i] = 0;
    for (int i = 0; i < 7; i++) begin fq[i] = 0; dm[i] = 0; end
    for (int i = 0; i < 8; i++) pv[i] = 0;
    mmode = 5'd19;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    chk("R1", 32'(cur_mode_o), 32'd19);
    chk("R1", 32'(cur_bank_o), 32'd3);
    for (int r = 0; r < 16; r++) begin ra_addr = 4'(r); #1; chk("R1", ra_data, 0); end

    // R2 and R3: every mode number
    for (int m = 0; m < 32; m++) begin
      set_mode(5'(m)); #1;
      chk("R3", 32'(cur_mode_o), 32'(m));
      chk("R2", 32'(cur_bank_o), 32'(mb(5'(m))));
    end

    // R4-R9: write everything in every mode, read from every view
    for (int m = 0; m < 32; m++) begin
      set_mode(5'(m));
      for (int r = 0; r < 16; r++) core_wr(4'(r), 32'hA500_0000 | (m << 8) | r);
      sweep_core();
      sweep_dbg();
    end

    // R9: debug writes through every mode while in fast-interrupt mode
    set_mode(5'd17);
    for (int m = 0; m < 32; m++)
      for (int r = 0; r < 16; r++) begin
        dbg_mode = 5'(m); dbg_addr = 4'(r); dbg_wdata = 32'h5C00_0000 | (m << 8) | r;
        dbg_we = 1; tick(); dbg_we = 0;
      end
    sweep_core();
    sweep_dbg();
    set_mode(5'd7);
    sweep_dbg();

    // R10: not visible before the edge, visible after
    set_mode(5'd16);
    core_wr(4'd5, 32'h1111_0005);
    ra_addr = 4'd5; waddr = 4'd5; wdata = 32'h2222_0005; we = 1; #1;
    chk("R10", ra_data, 32'h1111_0005);
    tick(); we = 0; #1;
    chk("R10", ra_data, 32'h2222_0005);

    // R3: write in the mode-change cycle lands in the old mode
    waddr = 4'd10; wdata = 32'h3333_000A; we = 1; mode_in = 5'd17; mode_we = 1;
    tick(); we = 0; mode_we = 0;
    ra_addr = 4'd10; #1;
    chk("R3", ra_data, mrd(3'd1, 4'd10, 1'b1));
    dbg_mode = 5'd16; dbg_addr = 4'd10; #1;
    chk("R3", dbg_rdata, 32'h3333_000A);
    waddr = 4'd13; wdata = 32'h3333_F13F; we = 1; tick(); we = 0;
    ra_addr = 4'd13; #1;
    chk("R3", ra_data, 32'h3333_F13F);

    // R11: collision on one physical register
    set_mode(5'd16);
    waddr = 4'd3; wdata = 32'hAAAA_0003; we = 1;
    dbg_mode = 5'd0; dbg_addr = 4'd3; dbg_wdata = 32'hBBBB_0003; dbg_we = 1;
    tick(); we = 0; dbg_we = 0;
    ra_addr = 4'd3; #1;
    chk("R11", ra_data, 32'hAAAA_0003);

    // R12: same-bank mode change
    set_mode(5'd18);
    core_wr(4'd13, 32'hC0DE_0013);
    core_wr(4'd9, 32'hC0DE_0009);
    set_mode(5'd2);
    ra_addr = 4'd13; rb_addr = 4'd9; #1;
    chk("R12", ra_data, 32'hC0DE_0013);
    chk("R12", rb_data, 32'hC0DE_0009);

    // R8: dummy bank life cycle
    set_mode(5'd20);
    ra_addr = 4'd9; #1; chk("R8", ra_data, 0);
    core_wr(4'd9, 32'hD00D_0009);
    #1; chk("R8", ra_data, 32'hD00D_0009);
    set_mode(5'd21);
    #1; chk("R8", ra_data, 32'hD00D_0009);
    dbg_mode = 5'd22; dbg_addr = 4'd9; #1; chk("R9", dbg_rdata, 32'hD00D_0009);
    set_mode(5'd16);
    dbg_mode = 5'd20; #1; chk("R9", dbg_rdata, 0);
    set_mode(5'd22);
    #1; chk("R8", ra_data, 0);
    set_mode(5'd31);
    sweep_core();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule